// File: doc/BRIEF.md
# Dual-Mode Interrupt Acceptance Unit

This unit sits beside a CPU core and decides, once per clock, whether the core must enter its hardware-interrupt handler. It also keeps the processor status fields that take part in that decision. The configuration is fixed when the design is elaborated, by the parameter `EXT_MODE`.

With `EXT_MODE = 0` (internal mode) the unit samples a vector of level-sensitive interrupt lines into a pending register. It also keeps an enable register that software can write. With `EXT_MODE = 1` (external mode) the unit instead samples a single request channel from an external controller. That channel carries a valid bit, a non-maskable flag, a requested interrupt level and a requested register set. The request is accepted or refused by comparing it with the status fields.

An accepted interrupt produces a one-cycle registered strobe. The strobe comes with the accepted level, register set and non-maskable flag. In the same edge the unit updates its own status fields. The core can also reload the whole status word, for example on return from an exception. The control-register write port changes only the fields that are writable in the selected mode.

Top module: `irq_accept_unit`

## Requirements
- R1: In internal mode `pending_o` shows `irq_lines` as sampled at the previous clock edge, and `enable_o` holds the last value written with `csr_sel = 1`. In external mode both `pending_o` and `enable_o` read zero, and writes with `csr_sel = 1` have no effect.
- R2: In internal mode a take is raised only when status PIE (bit 0) is 1 and `pending & enable` is nonzero.
- R3: In external mode a valid non-maskable request is taken whenever status NMI (bit 1) is 0, whatever PIE, IL and CRS hold. A take of that kind sets NMI, so a request that stays asserted is taken only once.
- R4: In external mode a valid maskable request is never taken while PIE is 0.
- R5: In external mode a maskable request is taken only if its level is strictly greater than status IL (bits 9:4). On such a take, IL is loaded with the accepted level.
- R6: In external mode a maskable request that passes the checks of R4 and R5 is taken when its register set differs from status CRS (bits 15:10). When it names the current set, it is taken only if RSIE (bit 2) is 1. Every external take loads CRS with the accepted set.
- R7: Status write (`csr_we` with `csr_sel = 0`):
  - In internal mode only PIE changes.
  - In external mode PIE, RSIE, IH (bit 3), IL and PRS (bits 21:16) take the written values.
  - NMI and CRS are never changed by this port.
- R8: External requests are level-sensitive. A request is considered only in the cycle after `req_valid` was sampled high. With `req_valid` low, nothing is taken.
- R9: `take_o` is a one-cycle pulse, registered one edge after the deciding cycle. On each take, PIE is cleared in that same edge. `take_level_o`, `take_rs_o` and `take_nmi_o` give the accepted request. In internal mode they read zero.
- R10: Reset clears the status word, the enable and pending registers, and `take_o`.
- R11: While `restore_en` is high, the status word is loaded from `restore_word` and no take is raised. Internal mode loads PIE only; external mode loads every defined field. `restore_en` takes priority over a status write and over a take in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | NUM_IRQ | Level-sensitive interrupt lines (internal mode) |
| req_valid | input | 1 | External request present |
| req_nmi | input | 1 | External request is non-maskable |
| req_level | input | 6 | Requested interrupt level |
| req_rs | input | 6 | Requested register set |
| csr_we | input | 1 | Control-register write strobe |
| csr_sel | input | 1 | 0 selects status, 1 selects enable |
| csr_wdata | input | 32 | Control-register write data |
| restore_en | input | 1 | Load the status word from `restore_word` |
| restore_word | input | 32 | Status value to restore |
| status_o | output | 32 | Current status word |
| enable_o | output | NUM_IRQ | Enable register |
| pending_o | output | NUM_IRQ | Pending register |
| take_o | output | 1 | Take-interrupt strobe |
| take_level_o | output | 6 | Level of the accepted request |
| take_rs_o | output | 6 | Register set of the accepted request |
| take_nmi_o | output | 1 | Accepted request was non-maskable |

## Verification
The assertions assume that the core never reloads the status word to re-arm PIE, or to clear NMI, in the very cycle that follows a take. The single-pulse property depends on that assumption. The assertions also assume that `restore_en` is the only path by which NMI returns to zero.

The stimulus keeps to these rules by issuing restores only in separate phases, or at random times that are checked against the reference model rather than against the properties. Requests and lines are held for several cycles so that the level-sensitive sampling is exercised both as a steady level and as a withdrawal.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  localparam int LVL_W  = 6;
  localparam int RS_W   = 6;
  localparam int CSR_W  = 32;
  localparam int RSVD_W = CSR_W - 4 - LVL_W - 2 * RS_W;

  // Status word, most significant field first.
  // pie[0] nmi[1] rsie[2] ih[3] il[9:4] crs[15:10] prs[21:16]
  typedef struct packed {
    logic [RSVD_W-1:0] rsvd;
    logic [RS_W-1:0]   prs;
    logic [RS_W-1:0]   crs;
    logic [LVL_W-1:0]  il;
    logic              ih;
    logic              rsie;
    logic              nmi;
    logic              pie;
  } status_t;

  typedef struct packed {
    logic             valid;
    logic             nmi;
    logic [LVL_W-1:0] level;
    logic [RS_W-1:0]  rs;
  } ext_req_t;

  typedef struct packed {
    logic             hit;
    logic             nmi;
    logic [LVL_W-1:0] level;
    logic [RS_W-1:0]  rs;
  } grant_t;

endpackage

// File: rtl/iac_iic_decide.sv
module iac_iic_decide #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic [NUM_IRQ-1:0] enable,
  input  logic               pie,
  input  logic               block,
  output logic [NUM_IRQ-1:0] pending_o,
  output logic               hit_o
);

  logic [NUM_IRQ-1:0] pend_d, pend_q;
  logic               any_live;

  always_comb begin
    pend_d = irq_lines;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_comb begin
    any_live = |(pend_q & enable);
    hit_o    = pie && any_live && !block;
  end

  assign pending_o = pend_q;

  // R1: pending register follows the lines with one cycle of lag.
  assert_pend_lag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend_q == $past(irq_lines))
    else $error("pending did not follow lines");

endmodule

// File: rtl/iac_eic_decide.sv
module iac_eic_decide
  import irq_accept_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ext_req_t         req_in,
  input  logic             pie,
  input  logic             nmi,
  input  logic             rsie,
  input  logic [LVL_W-1:0] il,
  input  logic [RS_W-1:0]  crs,
  input  logic             block,
  output grant_t           grant_o
);

  ext_req_t req_d, req_q;
  logic     lvl_above, set_other, mask_ok, nmi_ok;

  always_comb begin
    req_d = req_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else begin
      req_q <= req_d;
    end
  end

  always_comb begin
    lvl_above     = req_q.level > il;
    set_other     = req_q.rs != crs;
    mask_ok       = pie && lvl_above && (set_other || rsie);
    nmi_ok        = !nmi;
    grant_o.hit   = !block && req_q.valid && (req_q.nmi ? nmi_ok : mask_ok);
    grant_o.nmi   = req_q.nmi;
    grant_o.level = req_q.level;
    grant_o.rs    = req_q.rs;
  end

  // R8: nothing is granted unless a valid request was sampled.
  assert_no_grant_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_in.valid) |-> !grant_o.hit)
    else $error("grant without sampled request");

endmodule

// File: rtl/iac_status_regs.sv
module iac_status_regs
  import irq_accept_pkg::*;
#(
  parameter bit EXT_MODE = 1'b0,
  parameter int NUM_IRQ  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_we,
  input  logic               csr_sel,
  input  logic [CSR_W-1:0]   csr_wdata,
  input  logic               restore_en,
  input  logic [CSR_W-1:0]   restore_word,
  input  grant_t             grant,
  output status_t            status_o,
  output logic [NUM_IRQ-1:0] enable_o
);

  status_t st_d, st_q, wr_view, rs_view;
  logic    st_en, wr_status, wr_enable;
  logic    unused_wbits;

  assign unused_wbits = ^{csr_wdata, restore_word};
  assign wr_view      = status_t'(csr_wdata);
  assign rs_view      = status_t'(restore_word);

  always_comb begin
    wr_status = csr_we && !csr_sel;
    wr_enable = csr_we && csr_sel;
    st_en     = restore_en || wr_status || grant.hit;
  end

  always_comb begin
    st_d = st_q;
    if (restore_en) begin
      if (EXT_MODE) begin
        st_d      = rs_view;
        st_d.rsvd = '0;
      end else begin
        st_d.pie = rs_view.pie;
      end
    end else begin
      if (wr_status) begin
        st_d.pie = wr_view.pie;
        if (EXT_MODE) begin
          st_d.rsie = wr_view.rsie;
          st_d.ih   = wr_view.ih;
          st_d.il   = wr_view.il;
          st_d.prs  = wr_view.prs;
        end
      end
      if (grant.hit) begin
        st_d.pie = 1'b0;
        if (EXT_MODE) begin
          st_d.crs = grant.rs;
          if (grant.nmi) begin
            st_d.nmi = 1'b1;
          end else begin
            st_d.il = grant.level;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  generate
    if (EXT_MODE) begin : g_no_enable
      logic unused_en_wr;
      assign unused_en_wr = wr_enable;
      assign enable_o     = '0;
    end else begin : g_enable
      logic [NUM_IRQ-1:0] en_d, en_q;
      always_comb begin
        en_d = csr_wdata[NUM_IRQ-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q <= '0;
        end else if (wr_enable) begin
          en_q <= en_d;
        end
      end
      assign enable_o = en_q;
    end
  endgenerate

  assign status_o = st_q;

  // R7: the write port alone never moves the read-only fields.
  assert_ro_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !restore_en && !grant.hit) |=> ($stable(st_q.crs) && $stable(st_q.nmi)))
    else $error("read-only status field changed by write");

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter bit EXT_MODE = 1'b0,
  parameter int NUM_IRQ  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               req_valid,
  input  logic               req_nmi,
  input  logic [LVL_W-1:0]   req_level,
  input  logic [RS_W-1:0]    req_rs,
  input  logic               csr_we,
  input  logic               csr_sel,
  input  logic [CSR_W-1:0]   csr_wdata,
  input  logic               restore_en,
  input  logic [CSR_W-1:0]   restore_word,
  output logic [CSR_W-1:0]   status_o,
  output logic [NUM_IRQ-1:0] enable_o,
  output logic [NUM_IRQ-1:0] pending_o,
  output logic               take_o,
  output logic [LVL_W-1:0]   take_level_o,
  output logic [RS_W-1:0]    take_rs_o,
  output logic               take_nmi_o
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  status_t                status;
  grant_t                 grant;
  logic [NUM_IRQ-1:0]     pend;
  logic [NUM_IRQ-1:0]     en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  iac_status_regs #(
    .EXT_MODE (EXT_MODE),
    .NUM_IRQ  (NUM_IRQ)
  ) u_status (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .csr_we       (csr_we),
    .csr_sel      (csr_sel),
    .csr_wdata    (csr_wdata),
    .restore_en   (restore_en),
    .restore_word (restore_word),
    .grant        (grant),
    .status_o     (status),
    .enable_o     (en)
  );

  generate
    if (EXT_MODE) begin : g_ext
      ext_req_t req;
      logic     unused_lines;
      assign unused_lines = ^{irq_lines, en};
      assign req.valid    = req_valid;
      assign req.nmi      = req_nmi;
      assign req.level    = req_level;
      assign req.rs       = req_rs;
      assign pend         = '0;

      iac_eic_decide u_dec (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .req_in  (req),
        .pie     (status.pie),
        .nmi     (status.nmi),
        .rsie    (status.rsie),
        .il      (status.il),
        .crs     (status.crs),
        .block   (restore_en),
        .grant_o (grant)
      );
    end else begin : g_int
      logic hit;
      logic unused_req;
      assign unused_req = ^{req_valid, req_nmi, req_level, req_rs};

      iac_iic_decide #(
        .NUM_IRQ (NUM_IRQ)
      ) u_dec (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .irq_lines (irq_lines),
        .enable    (en),
        .pie       (status.pie),
        .block     (restore_en),
        .pending_o (pend),
        .hit_o     (hit)
      );

      assign grant.hit   = hit;
      assign grant.nmi   = 1'b0;
      assign grant.level = '0;
      assign grant.rs    = '0;
    end
  endgenerate

  logic             take_d, take_q, take_nmi_q;
  logic [LVL_W-1:0] take_lvl_q;
  logic [RS_W-1:0]  take_rs_q;

  always_comb begin
    take_d = grant.hit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      take_q <= 1'b0;
    end else begin
      take_q <= take_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      take_lvl_q <= '0;
      take_rs_q  <= '0;
      take_nmi_q <= 1'b0;
    end else if (grant.hit) begin
      take_lvl_q <= grant.level;
      take_rs_q  <= grant.rs;
      take_nmi_q <= grant.nmi;
    end
  end

  assign status_o     = status;
  assign enable_o     = en;
  assign pending_o    = pend;
  assign take_o       = take_q;
  assign take_level_o = take_lvl_q;
  assign take_rs_o    = take_rs_q;
  assign take_nmi_o   = take_nmi_q;

  // R9: strobe lasts one cycle and PIE drops with it.
  assert_take_single_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take_q |=> !take_q)
    else $error("take strobe longer than one cycle");

  assert_take_clears_pie_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take_q |-> !status.pie)
    else $error("PIE still set after take");

  generate
    if (EXT_MODE) begin : g_ext_chk
      // R3: a non-maskable take leaves NMI set.
      assert_nmi_latched_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (take_q && take_nmi_q) |-> status.nmi)
        else $error("NMI not latched");
      // R4: maskable takes only follow a cycle with PIE set.
      assert_mask_needs_pie_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (take_q && !take_nmi_q) |-> $past(status.pie))
        else $error("maskable take without PIE");
      // R5: the accepted level lands in IL.
      assert_il_loaded_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (take_q && !take_nmi_q) |-> (status.il == take_lvl_q))
        else $error("IL not loaded on take");
      // R6: the accepted register set lands in CRS.
      assert_crs_loaded_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
        take_q |-> (status.crs == take_rs_q))
        else $error("CRS not loaded on take");
    end else begin : g_int_chk
      // R2: every take follows an enabled pending line.
      assert_int_cause_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
        take_q |-> $past(|(pend & en)))
        else $error("take without enabled pending line");
    end
  endgenerate

endmodule

// File: tb/test_irq_accept_unit.sv
`timescale 1ns/1ps
module test_irq_accept_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        req_valid = 1'b0, req_nmi = 1'b0;
  logic [5:0]  req_level = '0, req_rs = '0;
  logic        csr_we = 1'b0, csr_sel = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic        restore_en = 1'b0;
  logic [31:0] restore_word = '0;

  logic [31:0] st_o   [2];
  logic [31:0] en_o   [2];
  logic [31:0] pend_o [2];
  logic        tk_o   [2];
  logic [5:0]  tl_o   [2];
  logic [5:0]  trs_o  [2];
  logic        tn_o   [2];

  always #2 clk = ~clk;

  irq_accept_unit #(.EXT_MODE(1'b0), .NUM_IRQ(32)) i_irq_accept_unit (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .req_valid(req_valid), .req_nmi(req_nmi), .req_level(req_level), .req_rs(req_rs),
    .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .restore_en(restore_en), .restore_word(restore_word),
    .status_o(st_o[0]), .enable_o(en_o[0]), .pending_o(pend_o[0]),
    .take_o(tk_o[0]), .take_level_o(tl_o[0]), .take_rs_o(trs_o[0]), .take_nmi_o(tn_o[0]));

  irq_accept_unit #(.EXT_MODE(1'b1), .NUM_IRQ(32)) i_irq_accept_unit_ext (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .req_valid(req_valid), .req_nmi(req_nmi), .req_level(req_level), .req_rs(req_rs),
    .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .restore_en(restore_en), .restore_word(restore_word),
    .status_o(st_o[1]), .enable_o(en_o[1]), .pending_o(pend_o[1]),
    .take_o(tk_o[1]), .take_level_o(tl_o[1]), .take_rs_o(trs_o[1]), .take_nmi_o(tn_o[1]));

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;
  int takes [2];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, index 0 internal, 1 external.
  bit        m_rs1, m_rs2;
  bit        m_pie [2], m_nmi [2], m_rsie [2], m_ih [2];
  bit [5:0]  m_il [2], m_crs [2], m_prs [2];
  bit [31:0] m_en [2];
  bit [31:0] m_pend;
  bit        m_rv, m_rn;
  bit [5:0]  m_rl, m_rr;
  bit        m_take [2], m_tn [2];
  bit [5:0]  m_tl [2], m_trs [2];

  function automatic bit [31:0] m_word(input int m);
    return {10'd0, m_prs[m], m_crs[m], m_il[m], m_ih[m], m_rsie[m], m_nmi[m], m_pie[m]};
  endfunction

  task automatic m_clear();
    for (int m = 0; m < 2; m++) begin
      m_pie[m] = 0; m_nmi[m] = 0; m_rsie[m] = 0; m_ih[m] = 0;
      m_il[m] = 0; m_crs[m] = 0; m_prs[m] = 0; m_en[m] = 0;
      m_take[m] = 0; m_tn[m] = 0; m_tl[m] = 0; m_trs[m] = 0;
    end
    m_pend = 0; m_rv = 0; m_rn = 0; m_rl = 0; m_rr = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0;
      m_clear();
    end else begin
      if (!m_rs2) begin
        m_clear();
      end else begin
        for (int m = 0; m < 2; m++) begin
          bit acc;
          if (m == 0)
            acc = !restore_en && m_pie[0] && ((m_pend & m_en[0]) != 0);
          else
            acc = !restore_en && m_rv &&
                  (m_rn ? !m_nmi[1]
                        : (m_pie[1] && (m_rl > m_il[1]) && ((m_rr != m_crs[1]) || m_rsie[1])));
          m_take[m] = acc;
          if (acc && m == 1) begin
            m_tl[1] = m_rl; m_trs[1] = m_rr; m_tn[1] = m_rn;
          end
          if (restore_en) begin
            m_pie[m] = restore_word[0];
            if (m == 1) begin
              m_nmi[1] = restore_word[1]; m_rsie[1] = restore_word[2];
              m_ih[1] = restore_word[3]; m_il[1] = restore_word[9:4];
              m_crs[1] = restore_word[15:10]; m_prs[1] = restore_word[21:16];
            end
          end else begin
            if (csr_we && !csr_sel) begin
              m_pie[m] = csr_wdata[0];
              if (m == 1) begin
                m_rsie[1] = csr_wdata[2]; m_ih[1] = csr_wdata[3];
                m_il[1] = csr_wdata[9:4]; m_prs[1] = csr_wdata[21:16];
              end
            end
            if (acc) begin
              m_pie[m] = 0;
              if (m == 1) begin
                m_crs[1] = m_rr;
                if (m_rn) m_nmi[1] = 1; else m_il[1] = m_rl;
              end
            end
          end
          if (m == 0 && csr_we && csr_sel) m_en[0] = csr_wdata;
        end
        m_pend = irq_lines;
        m_rv = req_valid; m_rn = req_nmi; m_rl = req_level; m_rr = req_rs;
      end
      m_rs2 = m_rs1; m_rs1 = 1;
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (tk_o[m]) takes[m]++;
      if (cmp_on) begin
        check(m ? "R7 status ext" : "R7 status int", st_o[m], m_word(m));
        check("R1 enable", en_o[m], m_en[m]);
        check("R1 pending", pend_o[m], (m == 0) ? m_pend : 32'd0);
        check(m ? "R9 take ext" : "R2 take int", {31'd0, tk_o[m]}, {31'd0, m_take[m]});
        if (m_take[m] && m == 1) begin
          check("R9 take level", {26'd0, tl_o[1]}, {26'd0, m_tl[1]});
          check("R6 take rs", {26'd0, trs_o[1]}, {26'd0, m_trs[1]});
          check("R3 take nmi", {31'd0, tn_o[1]}, {31'd0, m_tn[1]});
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mark();
    @(negedge clk);
    takes[0] = 0; takes[1] = 0;
  endtask

  task automatic csr_write(input logic sel, input logic [31:0] d);
    @(negedge clk); #0.5;
    csr_we = 1; csr_sel = sel; csr_wdata = d;
    @(negedge clk); #0.5;
    csr_we = 0;
  endtask

  task automatic do_restore(input logic [31:0] w, input int n);
    @(negedge clk); #0.5;
    restore_en = 1; restore_word = w;
    repeat (n) @(negedge clk);
    #0.5;
    restore_en = 0;
  endtask

  task automatic set_req(input logic v, input logic n, input logic [5:0] l, input logic [5:0] r);
    @(negedge clk); #0.5;
    req_valid = v; req_nmi = n; req_level = l; req_rs = r;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    idle(3);
    #0.5 rst_n = 1;
    idle(4);
    cmp_on = 1;
    // R10 reset state
    check("R10 status int", st_o[0], 0);
    check("R10 status ext", st_o[1], 0);
    check("R10 take", {31'd0, tk_o[0] | tk_o[1]}, 0);

    // R2: enabled line with PIE set is taken once
    csr_write(1, 32'h20);
    csr_write(0, 32'h1);
    mark();
    #0.5 irq_lines = 32'h20;
    idle(5);
    #0.5 irq_lines = 0;
    idle(2);
    check("R2 int takes", takes[0], 1);
    check("R8 ext no valid no take", takes[1], 0);
    check("R9 pie cleared int", {31'd0, st_o[0][0]}, 0);

    // R2: line not enabled is ignored
    do_restore(32'h1, 1);
    mark();
    #0.5 irq_lines = 32'h10;
    idle(5);
    #0.5 irq_lines = 0;
    idle(2);
    check("R2 int masked line", takes[0], 0);

    // R5: level must be strictly above IL
    csr_write(0, 32'h21);
    mark();
    set_req(1, 0, 6'd2, 6'd1);
    idle(5);
    check("R5 equal level refused", takes[1], 0);
    set_req(1, 0, 6'd3, 6'd1);
    idle(5);
    set_req(0, 0, 0, 0);
    idle(2);
    check("R5 higher level taken", takes[1], 1);
    check("R9 status after take", st_o[1], 32'h430);

    // R6: same register set needs RSIE
    do_restore(32'h431, 1);
    mark();
    set_req(1, 0, 6'd5, 6'd1);
    idle(5);
    check("R6 same set without RSIE", takes[1], 0);
    csr_write(0, 32'h1C37);
    check("R7 CRS read-only", {26'd0, st_o[1][15:10]}, 32'd1);
    check("R7 NMI read-only", {31'd0, st_o[1][1]}, 0);
    idle(4);
    set_req(0, 0, 0, 0);
    idle(2);
    check("R6 same set with RSIE", takes[1], 1);

    // R4 and R3
    do_restore(32'h0, 1);
    mark();
    set_req(1, 0, 6'd9, 6'd2);
    idle(5);
    check("R4 PIE clear refuses", takes[1], 0);
    set_req(1, 1, 6'd0, 6'd3);
    idle(8);
    check("R3 NMI taken once", takes[1], 1);
    check("R3 NMI bit set", {31'd0, st_o[1][1]}, 1);

    // R11: restore holds off a take while active
    mark();
    do_restore(32'h0, 3);
    check("R11 restore suppresses", takes[1], 0);
    idle(3);
    set_req(0, 0, 0, 0);
    idle(2);
    check("R11 taken after restore", takes[1], 1);

    // R1: pending follows lines one cycle later
    @(negedge clk); #0.5 irq_lines = 32'hA5A5_0F0F;
    @(negedge clk);
    check("R1 pending int", pend_o[0], 32'hA5A5_0F0F);
    check("R1 pending ext zero", pend_o[1], 0);
    check("R1 enable ext zero", en_o[1], 0);
    #0.5 irq_lines = 0;

    // Mixed stimulus against the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #0.5;
      irq_lines    = $urandom & 32'h0000_00FF;
      req_valid    = ($urandom % 4) != 0;
      req_nmi      = ($urandom % 8) == 0;
      req_level    = 6'($urandom % 8);
      req_rs       = 6'($urandom % 4);
      csr_we       = ($urandom % 6) == 0;
      csr_sel      = $urandom % 2;
      csr_wdata    = $urandom;
      restore_en   = ($urandom % 10) == 0;
      restore_word = $urandom;
    end
    @(negedge clk); #0.5;
    csr_we = 0; restore_en = 0; req_valid = 0;
    idle(3);
    done = 1;
    summary();
  end

endmodule